// File: doc/BRIEF.md
# Multi-Channel Timer Bank with Deferred PWM Stop

The block holds a parameterised bank of general-purpose timers (eight by default). Each timer has its own configuration word, a period register, a width register and a running counter. A timer runs in one of three modes. In PWM mode it drives a pulse output. In capture mode it measures the high time and the full cycle time of an input. In edge-count mode it counts rising edges of its input. Software controls the bank through one simple synchronous write port and one combinational read port, with word addresses.

Three shared registers act on all timers at once, with one bit per timer. A start register sets a timer running on a write of 1. A stop register requests a stop on a write of 1. A run-status register shows which timers are counting. In capture and edge-count mode a stop request halts the timer on the next clock edge. In PWM mode the request is held pending and takes effect at the next period boundary (repeating PWM) or at the end of the pulse (single pulse). Software can cut a pending PWM stop short by writing 1 to the timer's run-status bit.

Address map (word addresses): 0 start, 1 stop, 2 run status. Timer i occupies addresses 4+4i to 7+4i, in this order: configuration, period, width, counter (read-only). Configuration bits [1:0] select the mode: 0 off, 1 PWM, 2 capture, 3 edge count. Bit 2 selects repeating PWM (1) or single pulse (0).

Top module: `ptimer_bank`

## Requirements
- R1: After reset every timer is stopped. The start, stop and run-status registers read 0, every counter reads 0, and every PWM output is low.
- R2: Writing 1 to bit i of the start register (address 0) sets timer i running from the next clock edge. Bits written as 0 change nothing. A start for a timer whose mode field is 0 is ignored.
- R3: Reading the start register, the stop register or the run-status register returns the run bits, with bit i set while timer i is counting. Configuration, period and width registers read back what was written.
- R4: In repeating PWM mode the output is high for the first `width` cycles of each period of `period` cycles and low for the rest. The counter runs 1..period and the output is high while counter <= width.
- R5: In repeating PWM mode a stop request keeps the timer running until the end of the period in progress. The run bit then clears on the edge that ends that period, and the output stays low after that.
- R6: In single-pulse PWM mode the output is high for `width` cycles, after which the timer stops by itself. A stop request made during the pulse does not shorten it.
- R7: Writing 1 to bit i of the run-status register (address 2) while timer i has a stop pending halts it on the next edge. The same write with no stop pending has no effect.
- R8: In capture mode the counter advances every cycle. At each rising input edge the counter value is stored as the period and the counter restarts at 1. At each falling edge the counter value is stored as the width. A high time of H cycles and a low time of L cycles give width H and period H+L.
- R9: In edge-count mode the counter increments once per rising edge of the timer's input, starting from 0 at start.
- R10: In capture and edge-count modes a stop request clears the run bit on the next edge. After that, input edges change neither the counter nor the captured registers.
- R11: Bits written as 0 to the stop register have no effect on a running timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Combinational read data |
| tmr_in | input | 8 | Per-timer capture / count input |
| pwm_out | output | 8 | Per-timer PWM output |

## Verification
The in-RTL properties check four things on every cycle: a stop request in capture or edge-count mode ends the run on the next edge, a stop request before the period end leaves a repeating PWM timer running, a forced stop and the end of a single pulse both halt the timer, and a pending stop never outlives its run. The exact waveforms need the bench's scenarios to show them. This covers the PWM high/low pattern, the cycle on which a deferred stop lands (both mid-period and on the boundary cycle), the measured width and period in capture mode, and the frozen counter after an immediate stop.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

   typedef enum logic [1:0] {
      MODE_OFF = 2'd0,
      MODE_PWM = 2'd1,
      MODE_CAP = 2'd2,
      MODE_EXT = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic      repeat_en;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam int REG_START  = 0;
   localparam int REG_STOP   = 1;
   localparam int REG_RUN    = 2;
   localparam int CH_BASE    = 4;
   localparam int CH_STRIDE  = 4;
   localparam int OFS_CFG    = 0;
   localparam int OFS_PER    = 1;
   localparam int OFS_WID    = 2;
   localparam int OFS_CNT    = 3;
   localparam int DATA_W     = 32;

   function automatic int map_addr_w(input int n_ch);
      return $clog2(CH_BASE + CH_STRIDE * n_ch);
   endfunction

endpackage

// File: rtl/ptimer_inedge.sv
module ptimer_inedge #(
   parameter bit IN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);

   logic lvl;
   logic lvl_prev;

   generate
      if (IN_REG) begin : g_staged
         logic stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= pin;
         end
         assign lvl = stage_q;
      end else begin : g_direct
         assign lvl = pin;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_prev <= 1'b0;
      else        lvl_prev <= lvl;
   end

   assign rise = lvl & ~lvl_prev;
   assign fall = ~lvl & lvl_prev;

endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
   import ptimer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_set,
   input  logic             dis_req,
   input  logic             force_stop,
   input  logic             cfg_we,
   input  logic             per_we,
   input  logic             wid_we,
   input  tmr_cfg_t         cfg_wdata,
   input  logic [CNT_W-1:0] val_wdata,
   input  logic             pin_rise,
   input  logic             pin_fall,
   output logic             run,
   output tmr_cfg_t         cfg,
   output logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] width,
   output logic [CNT_W-1:0] count,
   output logic             pwm_out
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   tmr_cfg_t         cfg_q;
   logic [CNT_W-1:0] per_q, wid_q, cnt_q, cnt_nxt;
   logic             run_q, pend_q, run_nxt, pend_nxt;
   logic             is_pwm, at_end, pend_want, stop_now, start_now;
   logic             cap_per, cap_wid;

   assign is_pwm    = (cfg_q.mode == MODE_PWM);
   assign at_end    = cfg_q.repeat_en ? (cnt_q >= per_q) : (cnt_q >= wid_q);
   assign pend_want = pend_q | (dis_req & is_pwm);

   assign stop_now  = run_q & ((dis_req & ~is_pwm)
                             | (is_pwm & at_end & (pend_want | ~cfg_q.repeat_en))
                             | (pend_q & force_stop));
   assign start_now = ~run_q & en_set & ~dis_req & (cfg_q.mode != MODE_OFF);

   assign cap_per = run_q & ~stop_now & (cfg_q.mode == MODE_CAP) & pin_rise;
   assign cap_wid = run_q & ~stop_now & (cfg_q.mode == MODE_CAP) & pin_fall;

   always_comb begin
      run_nxt  = run_q;
      pend_nxt = pend_q;
      cnt_nxt  = cnt_q;
      if (start_now) begin
         run_nxt  = 1'b1;
         pend_nxt = 1'b0;
         cnt_nxt  = is_pwm ? ONE : '0;
      end else if (stop_now) begin
         run_nxt  = 1'b0;
         pend_nxt = 1'b0;
      end else if (run_q) begin
         pend_nxt = pend_want;
         unique case (cfg_q.mode)
            MODE_PWM: cnt_nxt = at_end ? ONE : cnt_q + ONE;
            MODE_CAP: cnt_nxt = pin_rise ? ONE : cnt_q + ONE;
            MODE_EXT: cnt_nxt = pin_rise ? cnt_q + ONE : cnt_q;
            default:  cnt_nxt = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         per_q  <= '0;
         wid_q  <= '0;
         cnt_q  <= '0;
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (cfg_we) cfg_q <= cfg_wdata;
         if (cap_per)     per_q <= cnt_q;
         else if (per_we) per_q <= val_wdata;
         if (cap_wid)     wid_q <= cnt_q;
         else if (wid_we) wid_q <= val_wdata;
         cnt_q  <= cnt_nxt;
         run_q  <= run_nxt;
         pend_q <= pend_nxt;
      end
   end

   assign run     = run_q;
   assign cfg     = cfg_q;
   assign period  = per_q;
   assign width   = wid_q;
   assign count   = cnt_q;
   assign pwm_out = run_q & is_pwm & (cnt_q != '0) & (cnt_q <= wid_q);

   // R10: capture and edge-count stop on the next edge
   assert_imm_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && dis_req && !is_pwm) |=> !run_q);

   // R5: repeating PWM keeps running while the period is unfinished
   assert_defer_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && is_pwm && cfg_q.repeat_en && dis_req && !at_end && !force_stop) |=> run_q);

   // R5: a pending stop only exists on a running timer
   assert_pend_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> run_q);

   // R7: forced stop of a pending PWM timer
   assert_force_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && force_stop) |=> !run_q);

   // R6: single pulse ends the run
   assert_pulse_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && is_pwm && !cfg_q.repeat_en && at_end) |=> !run_q);

   // R2: a timer in off mode is never started
   assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && cfg_q.mode == MODE_OFF) |=> !run_q);

endmodule

// File: rtl/ptimer_regif.sv
module ptimer_regif
   import ptimer_pkg::*;
#(
   parameter int NUM_TMR = 8,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 6
) (
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [ADDR_W-1:0]               rd_addr,
   input  logic [NUM_TMR-1:0]              run_vec,
   input  tmr_cfg_t [NUM_TMR-1:0]          cfg_arr,
   input  logic [NUM_TMR-1:0][CNT_W-1:0]   per_arr,
   input  logic [NUM_TMR-1:0][CNT_W-1:0]   wid_arr,
   input  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_arr,
   output logic [NUM_TMR-1:0]              en_set,
   output logic [NUM_TMR-1:0]              dis_req,
   output logic [NUM_TMR-1:0]              force_stop,
   output logic [NUM_TMR-1:0]              cfg_we,
   output logic [NUM_TMR-1:0]              per_we,
   output logic [NUM_TMR-1:0]              wid_we,
   output tmr_cfg_t                        cfg_wdata,
   output logic [CNT_W-1:0]                val_wdata,
   output logic [DATA_W-1:0]               rd_data
);

   function automatic logic [ADDR_W-1:0] ch_reg(input int ch, input int ofs);
      return ADDR_W'(CH_BASE + CH_STRIDE * ch + ofs);
   endfunction

   assign en_set     = (wr_en && wr_addr == ADDR_W'(REG_START)) ? wr_data[NUM_TMR-1:0] : '0;
   assign dis_req    = (wr_en && wr_addr == ADDR_W'(REG_STOP))  ? wr_data[NUM_TMR-1:0] : '0;
   assign force_stop = (wr_en && wr_addr == ADDR_W'(REG_RUN))   ? wr_data[NUM_TMR-1:0] : '0;
   assign cfg_wdata  = tmr_cfg_t'(wr_data[2:0]);
   assign val_wdata  = wr_data[CNT_W-1:0];

   generate
      for (genvar g = 0; g < NUM_TMR; g++) begin : g_dec
         assign cfg_we[g] = wr_en && (wr_addr == ch_reg(g, OFS_CFG));
         assign per_we[g] = wr_en && (wr_addr == ch_reg(g, OFS_PER));
         assign wid_we[g] = wr_en && (wr_addr == ch_reg(g, OFS_WID));
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_START) || rd_addr == ADDR_W'(REG_STOP) ||
          rd_addr == ADDR_W'(REG_RUN)) begin
         rd_data = DATA_W'(run_vec);
      end
      for (int i = 0; i < NUM_TMR; i++) begin
         if (rd_addr == ch_reg(i, OFS_CFG)) rd_data = DATA_W'(cfg_arr[i]);
         if (rd_addr == ch_reg(i, OFS_PER)) rd_data = DATA_W'(per_arr[i]);
         if (rd_addr == ch_reg(i, OFS_WID)) rd_data = DATA_W'(wid_arr[i]);
         if (rd_addr == ch_reg(i, OFS_CNT)) rd_data = DATA_W'(cnt_arr[i]);
      end
   end

endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
   import ptimer_pkg::*;
#(
   parameter int  NUM_TMR = 8,
   parameter int  CNT_W   = 32,
   parameter bit  IN_REG  = 1'b0,
   localparam int ADDR_W  = map_addr_w(NUM_TMR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_TMR-1:0] tmr_in,
   output logic [NUM_TMR-1:0] pwm_out
);

   generate
      if (NUM_TMR < 1 || NUM_TMR > 16) begin : g_bad_num
         $error("ptimer_bank: NUM_TMR must be 1..16");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("ptimer_bank: CNT_W must be 2..32");
      end
   endgenerate

   logic [NUM_TMR-1:0]            en_set, dis_req, force_stop;
   logic [NUM_TMR-1:0]            cfg_we, per_we, wid_we;
   tmr_cfg_t                      cfg_wdata;
   logic [CNT_W-1:0]              val_wdata;
   logic [NUM_TMR-1:0]            run_vec, rise_vec, fall_vec;
   tmr_cfg_t [NUM_TMR-1:0]        cfg_arr;
   logic [NUM_TMR-1:0][CNT_W-1:0] per_arr, wid_arr, cnt_arr;

   ptimer_regif #(
      .NUM_TMR (NUM_TMR),
      .CNT_W   (CNT_W),
      .ADDR_W  (ADDR_W)
   ) regif_i (
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .run_vec    (run_vec),
      .cfg_arr    (cfg_arr),
      .per_arr    (per_arr),
      .wid_arr    (wid_arr),
      .cnt_arr    (cnt_arr),
      .en_set     (en_set),
      .dis_req    (dis_req),
      .force_stop (force_stop),
      .cfg_we     (cfg_we),
      .per_we     (per_we),
      .wid_we     (wid_we),
      .cfg_wdata  (cfg_wdata),
      .val_wdata  (val_wdata),
      .rd_data    (rd_data)
   );

   generate
      for (genvar g = 0; g < NUM_TMR; g++) begin : g_ch
         ptimer_inedge #(.IN_REG(IN_REG)) edge_i (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (tmr_in[g]),
            .rise  (rise_vec[g]),
            .fall  (fall_vec[g])
         );

         ptimer_chan #(.CNT_W(CNT_W)) chan_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_set     (en_set[g]),
            .dis_req    (dis_req[g]),
            .force_stop (force_stop[g]),
            .cfg_we     (cfg_we[g]),
            .per_we     (per_we[g]),
            .wid_we     (wid_we[g]),
            .cfg_wdata  (cfg_wdata),
            .val_wdata  (val_wdata),
            .pin_rise   (rise_vec[g]),
            .pin_fall   (fall_vec[g]),
            .run        (run_vec[g]),
            .cfg        (cfg_arr[g]),
            .period     (per_arr[g]),
            .width      (wid_arr[g]),
            .count      (cnt_arr[g]),
            .pwm_out    (pwm_out[g])
         );
      end
   endgenerate

endmodule

// File: tb/ptimer_bank_tb_top.sv
module ptimer_bank_tb_top;

   localparam int NT = 8;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NT-1:0] tmr_in = '0;
   logic [NT-1:0] pwm_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   bit [1:0] exp_q[$];
   string    tag_q[$];
   bit       mon_en = 0;
   int       mon_ch = 0;

   always #4 clk = ~clk;

   ptimer_bank #(.NUM_TMR(NT), .CNT_W(32)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .tmr_in  (tmr_in),
      .pwm_out (pwm_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   // monitor: pops expected {pwm,run} per cycle and compares
   always @(negedge clk) begin
      #2;
      if (mon_en && exp_q.size() > 0) begin
         bit [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, {30'd0, pwm_out[mon_ch], rd_data[mon_ch]}, {30'd0, e});
      end
   end

   // timer 0 PWM scenario: stop request in cycle d, optional forced stop in cycle f
   task automatic pwm_case(input int p, input int w, input bit rep, input int d,
                           input int f, input int m, input string tag);
      int stop_c;
      int cd;
      if (rep) begin
         cd = ((d - 1) % p) + 1;
         stop_c = d + p - cd;
      end else begin
         stop_c = w;
      end
      if (f > 0 && f < stop_c) stop_c = f;
      for (int c = 1; c <= m; c++) begin
         bit r;
         bit o;
         int cc;
         cc = rep ? ((c - 1) % p) + 1 : c;
         r = (c <= stop_c);
         o = r && (cc <= w);
         exp_q.push_back({o, r});
         tag_q.push_back(tag);
      end
      wr(4, {29'd0, rep, 2'd1});
      wr(5, p);
      wr(6, w);
      rd_addr = AW'(2);
      mon_ch = 0;
      wr(0, 32'h1);
      mon_en = 1;
      repeat (d - 1) @(negedge clk);
      wr(1, 32'h1);
      if (f > 0) begin
         repeat (f - d - 1) @(negedge clk);
         wr(2, 32'h1);
      end
      wait (exp_q.size() == 0);
      @(negedge clk);
      mon_en = 0;
   endtask

   task automatic pulse_in(input int ch, input int n);
      for (int k = 0; k < n; k++) begin
         tmr_in[ch] = 1'b1;
         @(negedge clk);
         tmr_in[ch] = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(0, v); chk("R1 start reg", v, 0);
      rd(1, v); chk("R1 stop reg", v, 0);
      rd(2, v); chk("R1 run reg", v, 0);
      rd(7, v); chk("R1 counter", v, 0);
      chk("R1 pwm low", {24'd0, pwm_out}, 0);
      @(negedge clk);

      // R4 R5: repeating PWM, stop requested mid-period
      pwm_case(5, 2, 1'b1, 8, 0, 14, "R4/R5 mid-period stop");
      // R5: stop requested on the boundary cycle itself
      pwm_case(4, 3, 1'b1, 4, 0, 7, "R5 boundary stop");
      // R6: single pulse, request during pulse does not shorten it
      pwm_case(9, 6, 1'b0, 2, 0, 9, "R6 single pulse");
      // R7: forced stop of a pending PWM stop
      pwm_case(10, 4, 1'b1, 2, 5, 8, "R7 forced stop");

      // R3: register readback
      rd(5, v); chk("R3 period readback", v, 10);
      rd(6, v); chk("R3 width readback", v, 4);
      rd(4, v); chk("R3 cfg readback", v, 32'h5);
      @(negedge clk);

      // R7 no pending / R11 zero bits
      wr(5, 6);
      wr(0, 32'h1);
      rd(2, v); chk("R2 started", v, 32'h1);
      @(negedge clk);
      wr(2, 32'h1);
      rd(2, v); chk("R7 run write without pending", v, 32'h1);
      @(negedge clk);
      wr(1, 32'h0);
      repeat (8) @(negedge clk);
      rd(2, v); chk("R11 zero stop bits", v, 32'h1);
      @(negedge clk);
      wr(1, 32'h1);
      wr(2, 32'h1);
      rd(2, v); chk("R7 forced stop status", v, 32'h0);
      chk("R7 pwm low after stop", {31'd0, pwm_out[0]}, 0);
      @(negedge clk);

      // R2: off mode ignored, zero bits ignored
      wr(8, 32'h0);
      wr(0, 32'h2);
      rd(0, v); chk("R2 off-mode start ignored", v, 0);
      @(negedge clk);
      wr(12, 32'h2);
      wr(0, 32'h0);
      rd(2, v); chk("R2 zero start bits", v, 0);
      @(negedge clk);
      wr(0, 32'h4);
      rd(2, v); chk("R2 capture started", v, 32'h4);
      rd(1, v); chk("R3 stop reg shows run", v, 32'h4);
      rd(0, v); chk("R3 start reg shows run", v, 32'h4);
      @(negedge clk);

      // R8: capture H=4 L=3
      tmr_in[2] = 1'b1; repeat (4) @(negedge clk);
      tmr_in[2] = 1'b0; repeat (3) @(negedge clk);
      tmr_in[2] = 1'b1; repeat (4) @(negedge clk);
      tmr_in[2] = 1'b0; @(negedge clk);
      rd(14, v); chk("R8 captured width", v, 4);
      rd(13, v); chk("R8 captured period", v, 7);
      @(negedge clk);

      // R10: immediate stop in capture mode
      wr(1, 32'h4);
      rd(2, v); chk("R10 capture stopped", v, 0);
      rd(15, c0);
      @(negedge clk);
      pulse_in(2, 3);
      rd(15, v); chk("R10 capture counter frozen", v, c0);
      rd(14, v); chk("R10 width unchanged", v, 4);
      @(negedge clk);

      // R9: edge counting
      wr(16, 32'h3);
      wr(0, 32'h8);
      pulse_in(3, 5);
      rd(19, v); chk("R9 edge count", v, 5);
      @(negedge clk);
      wr(1, 32'h8);
      rd(2, v); chk("R10 edge-count stopped", v, 0);
      @(negedge clk);
      pulse_in(3, 2);
      rd(19, v); chk("R10 edge count frozen", v, 5);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule